// File: doc/BRIEF.md
# Trap Entry Sequencer

This block moves a small 32-bit microcontroller core into a trap. Each cause code has its own request line. When the sequencer is idle and one or more lines are high, it takes the lowest-numbered cause. It then performs the architectural side effects of trap entry in three steps.

In the first step it writes three registers in the same cycle:
- FLAGS: the trap-active bit is raised, the three interrupt enables are copied into their save bits, and the enables are cleared.
- TSTATUS: the current PC is merged with the cause code.
- SP: the stack pointer is lowered by one word.

In the second step it writes the return PC to data memory at the new stack address. In the third step it loads PC from the trap-vector register.

The register file stays outside the block. The sequencer reads the current register values on plain input buses and writes back through per-register write strobes. The stack write uses a valid/ready stream with these back-pressure rules:
- While `mem_wvalid` is high and `mem_wready` is low, address and data hold steady.
- The write completes on the first clock edge with both high.
- The PC load follows in the next cycle.

A busy flag covers the whole sequence. Requests that arrive while busy is high are dropped.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `busy`, `flags_we`, `tstatus_we`, `sp_we`, `mem_wvalid` and `pc_we` are all low, and they stay low while no request is taken.
- R2: When several request lines are high in the same idle cycle, the lowest-numbered line `trap_req[k]` is taken and k becomes the cause code.
- R3: In the update cycle, the FLAGS write value equals the read value with these changes: bit 24 set to 1, bits 22:20 loaded with the old bits 18:16 (enables 0..2), and bits 18:16 cleared. All other bits are unchanged.
- R4: In the update cycle, TSTATUS is written with the current PC bitwise-OR'd with the 4-bit cause code shifted to bits 23:20.
- R5: In the update cycle, SP is written with the read SP minus 4.
- R6: In the cycle after the update, a stack write is offered. Its address is the decremented SP and its data is the PC read during the update. Address and data are held stable while `mem_wready` is low.
- R7: In the cycle after the stack write handshake, PC is written with the trap-vector register value.
- R8: `busy` is high from the cycle after a request is taken through the PC-load cycle. That is 3 cycles plus one cycle for each stalled stack-write cycle. Requests presented while busy is high produce no further writes.
- R9: Each trap produces exactly one FLAGS/TSTATUS/SP update, then one stack write, then one PC write, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 16 | One request line per cause code; a lower index has higher priority |
| busy | output | 1 | Trap entry in progress |
| pc_rd | input | 32 | Current PC |
| sp_rd | input | 32 | Current SP, word aligned |
| flags_rd | input | 32 | Current FLAGS |
| tv_rd | input | 32 | Trap-vector register |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC |
| sp_we | output | 1 | SP write strobe |
| sp_wdata | output | 32 | New SP |
| flags_we | output | 1 | FLAGS write strobe |
| flags_wdata | output | 32 | New FLAGS |
| tstatus_we | output | 1 | TSTATUS write strobe |
| tstatus_wdata | output | 32 | New TSTATUS |
| mem_wvalid | output | 1 | Stack write offered |
| mem_wready | input | 1 | Memory accepts the stack write |
| mem_waddr | output | 32 | Byte address of the stack word |
| mem_wdata | output | 32 | Return PC being pushed |

## Verification
The bench uses the default parameters: a 32-bit word, a 4-bit cause code with 16 request lines, and three interrupt enables. This configuration exercises every defined cause value, including the highest code 0xF, and lets several causes be requested together so that the priority pick can be checked. With three enables at their default positions, the save and clear of each enable shows up distinctly in the FLAGS write value. Stalling the stack write by several cycles brings the back-pressure rules and the stretched busy window into reach.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_UPD  = 2'd1,
    TS_PUSH = 2'd2,
    TS_JUMP = 2'd3
  } tseq_state_e;

endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter int N   = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  logic [N:0]   lower_seen;
  logic [N-1:0] grant;

  assign lower_seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]        = req[i] & ~lower_seen[i];
    assign lower_seen[i+1] = lower_seen[i] | req[i];
  end

  assign any = lower_seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/trap_word_build.sv
module trap_word_build #(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 4,
  parameter int CAUSE_LSB = 20,
  parameter int TA_BIT    = 24,
  parameter int IE_LSB    = 16,
  parameter int IS_LSB    = 20,
  parameter int NIE       = 3
) (
  input  logic [XLEN-1:0]    flags_cur,
  input  logic [XLEN-1:0]    pc_cur,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    flags_new,
  output logic [XLEN-1:0]    status_new
);

  logic [XLEN-1:0] save_mask;
  logic [XLEN-1:0] save_bits;
  logic [XLEN-1:0] en_mask;

  for (genvar e = 0; e < NIE; e++) begin : g_ie
    assign save_mask[IS_LSB+e] = 1'b1;
    assign save_bits[IS_LSB+e] = flags_cur[IE_LSB+e];
    assign en_mask[IE_LSB+e]   = 1'b1;
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_fill
    if (!((b >= IS_LSB) && (b < IS_LSB + NIE))) begin : g_nosave
      assign save_mask[b] = 1'b0;
      assign save_bits[b] = 1'b0;
    end
    if (!((b >= IE_LSB) && (b < IE_LSB + NIE))) begin : g_noen
      assign en_mask[b] = 1'b0;
    end
  end

  always_comb begin
    flags_new         = (flags_cur & ~save_mask & ~en_mask) | save_bits;
    flags_new[TA_BIT] = 1'b1;
    status_new        = pc_cur | (XLEN'(cause) << CAUSE_LSB);
  end

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_any,
  input  logic [CAUSE_W-1:0] req_idx,
  input  logic [XLEN-1:0]    pc_cur,
  input  logic [XLEN-1:0]    sp_cur,
  input  logic               push_ready,
  output tseq_state_e        state,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    sp_down,
  output logic [XLEN-1:0]    push_addr,
  output logic [XLEN-1:0]    push_data
);

  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  assign sp_down = sp_cur - STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TS_IDLE;
      cause_q   <= '0;
      push_addr <= '0;
      push_data <= '0;
    end else begin
      unique case (state)
        TS_IDLE: begin
          if (req_any) begin
            cause_q <= req_idx;
            state   <= TS_UPD;
          end
        end
        TS_UPD: begin
          push_addr <= sp_down;
          push_data <= pc_cur;
          state     <= TS_PUSH;
        end
        TS_PUSH: begin
          if (push_ready) state <= TS_JUMP;
        end
        TS_JUMP: state <= TS_IDLE;
        default: state <= TS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int CAUSE_LSB  = 20,
  parameter int TA_BIT     = 24,
  parameter int IE_LSB     = 16,
  parameter int IS_LSB     = 20,
  parameter int NIE        = 3,
  parameter int WORD_BYTES = 4,
  localparam int NCAUSE    = 1 << CAUSE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] trap_req,
  output logic              busy,
  input  logic [XLEN-1:0]   pc_rd,
  input  logic [XLEN-1:0]   sp_rd,
  input  logic [XLEN-1:0]   flags_rd,
  input  logic [XLEN-1:0]   tv_rd,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_wdata,
  output logic              sp_we,
  output logic [XLEN-1:0]   sp_wdata,
  output logic              flags_we,
  output logic [XLEN-1:0]   flags_wdata,
  output logic              tstatus_we,
  output logic [XLEN-1:0]   tstatus_wdata,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [XLEN-1:0]   mem_waddr,
  output logic [XLEN-1:0]   mem_wdata
);

  logic               pick_any;
  logic [CAUSE_W-1:0] pick_idx;
  tseq_state_e        st;
  logic [CAUSE_W-1:0] cause_q;
  logic [XLEN-1:0]    sp_down;

  trap_prio_pick #(.N(NCAUSE), .IDX_W(CAUSE_W)) u_pick (
    .req (trap_req),
    .any (pick_any),
    .idx (pick_idx)
  );

  trap_seq_fsm #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .WORD_BYTES(WORD_BYTES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_any    (pick_any),
    .req_idx    (pick_idx),
    .pc_cur     (pc_rd),
    .sp_cur     (sp_rd),
    .push_ready (mem_wready),
    .state      (st),
    .cause_q    (cause_q),
    .sp_down    (sp_down),
    .push_addr  (mem_waddr),
    .push_data  (mem_wdata)
  );

  trap_word_build #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_LSB(CAUSE_LSB), .TA_BIT(TA_BIT),
    .IE_LSB(IE_LSB), .IS_LSB(IS_LSB), .NIE(NIE)
  ) u_build (
    .flags_cur  (flags_rd),
    .pc_cur     (pc_rd),
    .cause      (cause_q),
    .flags_new  (flags_wdata),
    .status_new (tstatus_wdata)
  );

  assign busy       = (st != TS_IDLE);
  assign flags_we   = (st == TS_UPD);
  assign tstatus_we = (st == TS_UPD);
  assign sp_we      = (st == TS_UPD);
  assign sp_wdata   = sp_down;
  assign mem_wvalid = (st == TS_PUSH);
  assign pc_we      = (st == TS_JUMP);
  assign pc_wdata   = tv_rd;

endmodule

// File: rtl/trap_entry_sva.sv
module trap_entry_sva #(
  parameter int XLEN   = 32,
  parameter int TA_BIT = 24,
  parameter int IE_LSB = 16,
  parameter int NIE    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            pc_we,
  input logic            sp_we,
  input logic [XLEN-1:0] sp_wdata,
  input logic            flags_we,
  input logic [XLEN-1:0] flags_wdata,
  input logic            tstatus_we,
  input logic            mem_wvalid,
  input logic            mem_wready,
  input logic [XLEN-1:0] mem_waddr,
  input logic [XLEN-1:0] mem_wdata
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!flags_we && !tstatus_we && !sp_we && !mem_wvalid && !pc_we));

  p_trap_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> flags_wdata[TA_BIT]);

  p_enables_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (flags_wdata[IE_LSB +: NIE] == '0));

  p_push_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> (mem_waddr == $past(sp_wdata)));

  p_push_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  p_jump_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && mem_wready) |=> pc_we);

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> busy);

  p_push_after_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> (mem_wvalid && !flags_we));

  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flags_we, mem_wvalid, pc_we}) <= 1);

endmodule

bind trap_entry_seq trap_entry_sva #(
  .XLEN(XLEN), .TA_BIT(TA_BIT), .IE_LSB(IE_LSB), .NIE(NIE)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .pc_we       (pc_we),
  .sp_we       (sp_we),
  .sp_wdata    (sp_wdata),
  .flags_we    (flags_we),
  .flags_wdata (flags_wdata),
  .tstatus_we  (tstatus_we),
  .mem_wvalid  (mem_wvalid),
  .mem_wready  (mem_wready),
  .mem_waddr   (mem_waddr),
  .mem_wdata   (mem_wdata)
);

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;

  localparam int K_FLAGS = 0;
  localparam int K_TST   = 1;
  localparam int K_SP    = 2;
  localparam int K_MEM   = 3;
  localparam int K_PC    = 4;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trap_req = '0;
  logic        busy;
  logic [31:0] pc_r = 32'h0000_1200;
  logic [31:0] sp_r = 32'h0000_8000;
  logic [31:0] flags_r = 32'h0007_00C3;
  logic [31:0] tv_r = 32'h0000_0400;
  logic        pc_we, sp_we, flags_we, tstatus_we, mem_wvalid;
  logic        mem_wready = 1'b1;
  logic [31:0] pc_wdata, sp_wdata, flags_wdata, tstatus_wdata, mem_waddr, mem_wdata;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  trap_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .busy(busy),
    .pc_rd(pc_r), .sp_rd(sp_r), .flags_rd(flags_r), .tv_rd(tv_r),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .flags_we(flags_we), .flags_wdata(flags_wdata),
    .tstatus_we(tstatus_we), .tstatus_wdata(tstatus_wdata),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  task automatic report(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    if (q.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL R8/R9 unexpected write kind=%0d actual=%h expected=none", kind, d);
    end else begin
      e = q.pop_front();
      report(e.tag, $sformatf("kind %0d", e.kind), {32'(kind), 32'h0}, {32'(e.kind), 32'h0});
      report(e.tag, "addr/data", {a, d}, {e.addr, e.data});
    end
  endtask

  // Monitor: samples a little after each falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (flags_we)   observe(K_FLAGS, 32'h0, flags_wdata);
      if (tstatus_we) observe(K_TST, 32'h0, tstatus_wdata);
      if (sp_we)      observe(K_SP, 32'h0, sp_wdata);
      if (mem_wvalid && mem_wready) observe(K_MEM, mem_waddr, mem_wdata);
      if (pc_we)      observe(K_PC, 32'h0, pc_wdata);
    end
  end

  task automatic push_exp(input int kind, input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: one trap, expected items from the requirements
  task automatic run_trap(input logic [15:0] mask, input logic [15:0] extra,
                          input int stall, input logic [3:0] cause);
    logic [31:0] f;
    int cnt;
    int s;
    f = flags_r;
    f[22:20] = flags_r[18:16];
    f[18:16] = 3'b000;
    f[24]    = 1'b1;
    push_exp(K_FLAGS, 32'h0, f, "R3");
    push_exp(K_TST, 32'h0, pc_r | ({28'h0, cause} << 20), "R2/R4");
    push_exp(K_SP, 32'h0, sp_r - 32'd4, "R5");
    push_exp(K_MEM, sp_r - 32'd4, pc_r, "R6");
    push_exp(K_PC, 32'h0, tv_r, "R7");
    @(negedge clk);
    trap_req   = mask;
    mem_wready = (stall == 0);
    @(negedge clk);
    cnt = 0;
    s   = stall;
    forever begin
      if (!busy) break;
      cnt++;
      if (mem_wvalid) begin
        if (s == 0) mem_wready = 1'b1;
        else s--;
      end
      trap_req = extra;
      @(negedge clk);
    end
    trap_req   = '0;
    mem_wready = 1'b1;
    report("R8", "busy cycles", 64'(cnt), 64'(3 + stall));
    repeat (3) @(negedge clk);
    report("R9", "pending items", 64'(q.size()), 64'd0);
    // model register file takes the written values
    flags_r = f;
    sp_r    = sp_r - 32'd4;
    pc_r    = tv_r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1", "idle outputs", {58'h0, busy, flags_we, tstatus_we, sp_we, mem_wvalid, pc_we}, 64'h0);
    repeat (3) @(negedge clk);

    run_trap(16'h0001, 16'h0000, 0, 4'h0);                      // single software cause
    pc_r = 32'h0000_2344; tv_r = 32'h0000_0800; flags_r = 32'h0005_1000;
    run_trap(16'h0500, 16'h0000, 0, 4'h8);                      // R2: 8 and 0xA together
    pc_r = 32'h00F0_0010; flags_r = 32'h0002_0000;
    run_trap(16'hC008, 16'h0000, 0, 4'h3);                      // R2: 3 beats 0xE/0xF
    tv_r = 32'h0000_0C00;
    run_trap(16'h8000, 16'h0000, 3, 4'hF);                      // R6: stalled push
    flags_r = 32'h0003_0055;
    run_trap(16'h0800, 16'hFFFF, 1, 4'hB);                      // R8: requests while busy
    pc_r = 32'h0000_0100;
    run_trap(16'h0400, 16'h0000, 0, 4'hA);

    @(negedge clk);
    report("R1", "quiet after traps", {58'h0, busy, flags_we, tstatus_we, sp_we, mem_wvalid, pc_we}, 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule